// File: doc/BRIEF.md
# Banked Internal Data RAM Controller

This block is the 256-byte on-chip scratch memory of an 8-bit controller core. It takes three kinds of access: plain bytes, working registers R0 to R7, and single bits. It decides for each one whether the target is the local RAM or the external special-function-register (SFR) bus. The address alone does not settle this for the upper half. A byte at 0x80 to 0xFF is RAM when it is reached through a pointer and is an SFR when it is named directly.

The core presents a byte request, a register-number request and a bit request, together with the two bank-select bits from its status word. The block serves one of the three requests per clock. Reads are combinational on every port. A write, or a hand-off to the SFR bus, happens only for the request that wins arbitration. Writes commit on the rising clock edge. An indirect byte access uses R0 or R1 of the bank selected in that same cycle as its pointer.

Top module: `iram_bank_ctrl`

## Requirements
- R1: A direct byte access (byte_indirect=0) with byte_addr 0x00–0x7F reads and writes the RAM byte at byte_addr, and sfr_req stays low.
- R2: A direct byte access with byte_addr 0x80–0xFF is forwarded: sfr_req=1, sfr_addr=byte_addr, sfr_we=byte_we, sfr_wdata=byte_wdata, sfr_bit=0, and byte_rdata=sfr_rdata. The RAM is not modified.
- R3: An indirect byte access (byte_indirect=1) uses as its address the RAM byte at {3'b000, bank_sel, 2'b00, byte_ptr_sel}, where byte_ptr_sel 0 selects R0 and 1 selects R1. It reaches all 256 RAM bytes and never drives sfr_req.
- R4: A register access to reg_num n reads and writes the RAM byte {3'b000, bank_sel, n}.
- R5: A bit address 0x00–0x7F selects bit bit_addr[2:0] of RAM byte 0x20 + bit_addr[6:3]. A bit write changes only that bit of the byte.
- R6: A bit address 0x80–0xFF is forwarded: sfr_req=1, sfr_bit=1, sfr_addr=bit_addr, sfr_wdata={7'b0, bit_wdata}, and bit_rdata=sfr_rdata[0]. The RAM is not modified.
- R7: Writes take effect at the rising edge when the winning request has its write enable high. Read data is combinational, so it shows the old value before that edge and the new value right after it. A request with write enable low changes nothing.
- R8: When several requests are present, the byte port wins over the register port, and the register port wins over the bit port. Only the winner writes or forwards. The losers' read data still reflect the RAM.
- R9: A change of bank_sel takes effect in the same cycle, for both register accesses and indirect pointer selection.
- R10: While rst_n is low, no RAM write happens and sfr_req is low. Reset does not clear the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; blocks writes and forwarding |
| bank_sel | input | 2 | Active register bank (status-word bits 4:3) |
| byte_req | input | 1 | Byte access request |
| byte_indirect | input | 1 | 1 = address comes from R0/R1, 0 = byte_addr is used |
| byte_ptr_sel | input | 1 | Pointer register for indirect access: 0 = R0, 1 = R1 |
| byte_addr | input | 8 | Direct byte address |
| byte_we | input | 1 | Byte write enable |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data |
| reg_req | input | 1 | Register access request |
| reg_num | input | 3 | Register number n of Rn |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| bit_req | input | 1 | Bit access request |
| bit_addr | input | 8 | Bit address |
| bit_we | input | 1 | Bit write enable |
| bit_wdata | input | 1 | Bit write value |
| bit_rdata | output | 1 | Bit read value |
| sfr_req | output | 1 | Forwarded access to the SFR bus |
| sfr_addr | output | 8 | Forwarded byte or bit address |
| sfr_we | output | 1 | Forwarded write enable |
| sfr_wdata | output | 8 | Forwarded write data (bit value in bit 0) |
| sfr_bit | output | 1 | Forwarded access is a bit access |
| sfr_rdata | input | 8 | Read data returned by the SFR bus |

## Verification
The bench sweeps every direct, indirect, register and bit address and compares each result against a shadow memory kept in the bench. The most important case is the upper half. The bench fills it through pointers, then hammers it with direct writes, then reads it back through pointers. A decoder that ignored the addressing mode would corrupt those bytes, or would leak pointer accesses onto the SFR bus. Bit writes start from mixed byte patterns, so a write that touched neighbouring bits, or a wrong byte/bit split of the bit address, would show up in the readback. Concurrent requests, bank changes within the same cycle, and writes attempted during reset target a mis-ordered arbiter, a pointer taken from the stale bank, and a reset that either clears or corrupts the RAM.

// File: rtl/iram_pkg.sv
// Package iram_pkg
// Shared sizes and constants for the banked internal data RAM.
// Assumes an 8-bit address and data path with 8 registers per bank.
package iram_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned REG_W    = 3;
    localparam int unsigned BANK_W   = 2;
    localparam int unsigned POS_W    = 3;
    localparam int unsigned N_RD     = 4;
    localparam int unsigned RD_PTR   = 0;
    localparam int unsigned RD_BYTE  = 1;
    localparam int unsigned RD_REG   = 2;
    localparam int unsigned RD_BIT   = 3;
    localparam logic [ADDR_W-1:0] BIT_BASE = 8'h20;
endpackage

// File: rtl/iram_store.sv
// Module iram_store
// Flop-based RAM with one synchronous write port and N_RD combinational
// read ports. No reset: the contents survive a reset of the block.
module iram_store #(
    parameter int unsigned AW  = 8,
    parameter int unsigned DW  = 8,
    parameter int unsigned NRD = 4
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Commit the single granted write on the rising edge.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One asynchronous read path per port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end
endmodule

// File: rtl/iram_decode.sv
// Module iram_decode
// Maps each port's request to a RAM address or an SFR hand-off.
// Assumes the pointer value is the RAM content at ptr_addr in the same cycle.
module iram_decode
    import iram_pkg::*;
(
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              byte_indirect,
    input  logic              byte_ptr_sel,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] ptr_val,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [ADDR_W-1:0] bit_addr,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic [ADDR_W-1:0] byte_ram_addr,
    output logic              byte_to_sfr,
    output logic [ADDR_W-1:0] reg_ram_addr,
    output logic [ADDR_W-1:0] bit_ram_addr,
    output logic [POS_W-1:0]  bit_pos,
    output logic              bit_to_sfr
);
    // Pointer register R0/R1 inside the currently selected bank.
    always_comb begin
        ptr_addr = ADDR_W'({bank_sel, REG_W'(byte_ptr_sel)});
    end

    // Byte port: indirect goes anywhere in RAM, direct upper half leaves.
    always_comb begin
        byte_ram_addr = byte_indirect ? ADDR_W'(ptr_val) : byte_addr;
        byte_to_sfr   = !byte_indirect && byte_addr[ADDR_W-1];
    end

    // Register port: bank bits above the register number.
    always_comb begin
        reg_ram_addr = ADDR_W'({bank_sel, reg_num});
    end

    // Bit port: low half indexes the bit field, upper half leaves.
    always_comb begin
        bit_to_sfr   = bit_addr[ADDR_W-1];
        bit_ram_addr = BIT_BASE + ADDR_W'(bit_addr[ADDR_W-2:POS_W]);
        bit_pos      = bit_addr[POS_W-1:0];
    end
endmodule

// File: rtl/iram_arbiter.sv
// Module iram_arbiter
// Picks one request per cycle (byte > register > bit), then builds the
// RAM write or the SFR hand-off for the winner. Nothing acts in reset.
module iram_arbiter
    import iram_pkg::*;
(
    input  logic              rst_n,
    input  logic              byte_req,
    input  logic              byte_we,
    input  logic [DATA_W-1:0] byte_wdata,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [ADDR_W-1:0] byte_ram_addr,
    input  logic              byte_to_sfr,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_ram_addr,
    input  logic              bit_req,
    input  logic              bit_we,
    input  logic              bit_wdata,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic [ADDR_W-1:0] bit_ram_addr,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              bit_to_sfr,
    input  logic [DATA_W-1:0] bit_byte,
    output logic [2:0]        grant,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              sfr_req,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic              sfr_we,
    output logic [DATA_W-1:0] sfr_wdata,
    output logic              sfr_bit
);
    logic [DATA_W-1:0] merged;

    // Fixed-priority choice of the single serviced request.
    always_comb begin
        grant = 3'b000;
        if (byte_req) begin
            grant = 3'b001;
        end else if (reg_req) begin
            grant = 3'b010;
        end else if (bit_req) begin
            grant = 3'b100;
        end
    end

    // Read-modify-write image of the addressed bit-field byte.
    always_comb begin
        merged          = bit_byte;
        merged[bit_pos] = bit_wdata;
    end

    // Route the winner to the RAM write port or the SFR bus.
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = '0;
        sfr_req   = 1'b0;
        sfr_addr  = '0;
        sfr_we    = 1'b0;
        sfr_wdata = '0;
        sfr_bit   = 1'b0;
        if (rst_n) begin
            if (grant[0]) begin
                if (byte_to_sfr) begin
                    sfr_req   = 1'b1;
                    sfr_addr  = byte_addr;
                    sfr_we    = byte_we;
                    sfr_wdata = byte_wdata;
                end else begin
                    mem_we    = byte_we;
                    mem_waddr = byte_ram_addr;
                    mem_wdata = byte_wdata;
                end
            end else if (grant[1]) begin
                mem_we    = reg_we;
                mem_waddr = reg_ram_addr;
                mem_wdata = reg_wdata;
            end else if (grant[2]) begin
                if (bit_to_sfr) begin
                    sfr_req   = 1'b1;
                    sfr_bit   = 1'b1;
                    sfr_addr  = bit_addr;
                    sfr_we    = bit_we;
                    sfr_wdata = DATA_W'(bit_wdata);
                end else begin
                    mem_we    = bit_we;
                    mem_waddr = bit_ram_addr;
                    mem_wdata = merged;
                end
            end
        end
    end
endmodule

// File: rtl/iram_bank_ctrl.sv
// Module iram_bank_ctrl
// Top of the banked internal data RAM: byte, register and bit ports over
// one 256-byte store, with direct upper-half accesses sent to the SFR bus.
// Assumes the core holds requests stable around the rising edge.
module iram_bank_ctrl
    import iram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bank_sel,
    input  logic              byte_req,
    input  logic              byte_indirect,
    input  logic              byte_ptr_sel,
    input  logic [7:0]        byte_addr,
    input  logic              byte_we,
    input  logic [7:0]        byte_wdata,
    output logic [7:0]        byte_rdata,
    input  logic              reg_req,
    input  logic [2:0]        reg_num,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              bit_req,
    input  logic [7:0]        bit_addr,
    input  logic              bit_we,
    input  logic              bit_wdata,
    output logic              bit_rdata,
    output logic              sfr_req,
    output logic [7:0]        sfr_addr,
    output logic              sfr_we,
    output logic [7:0]        sfr_wdata,
    output logic              sfr_bit,
    input  logic [7:0]        sfr_rdata
);
    logic [N_RD-1:0][ADDR_W-1:0] rd_addr;
    logic [N_RD-1:0][DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] ptr_addr, byte_ram_addr, reg_ram_addr, bit_ram_addr;
    logic [POS_W-1:0]  bit_pos;
    logic              byte_to_sfr, bit_to_sfr;
    logic [DATA_W-1:0] bit_byte;
    logic [2:0]        grant;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    iram_decode u_decode (
        .bank_sel      (bank_sel),
        .byte_indirect (byte_indirect),
        .byte_ptr_sel  (byte_ptr_sel),
        .byte_addr     (byte_addr),
        .ptr_val       (rd_data[RD_PTR]),
        .reg_num       (reg_num),
        .bit_addr      (bit_addr),
        .ptr_addr      (ptr_addr),
        .byte_ram_addr (byte_ram_addr),
        .byte_to_sfr   (byte_to_sfr),
        .reg_ram_addr  (reg_ram_addr),
        .bit_ram_addr  (bit_ram_addr),
        .bit_pos       (bit_pos),
        .bit_to_sfr    (bit_to_sfr)
    );

    // Gather the four read addresses for the store.
    always_comb begin
        rd_addr[RD_PTR]  = ptr_addr;
        rd_addr[RD_BYTE] = byte_ram_addr;
        rd_addr[RD_REG]  = reg_ram_addr;
        rd_addr[RD_BIT]  = bit_ram_addr;
    end

    iram_store #(.AW(ADDR_W), .DW(DATA_W), .NRD(N_RD)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign bit_byte = rd_data[RD_BIT];

    iram_arbiter u_arb (
        .rst_n         (rst_n),
        .byte_req      (byte_req),
        .byte_we       (byte_we),
        .byte_wdata    (byte_wdata),
        .byte_addr     (byte_addr),
        .byte_ram_addr (byte_ram_addr),
        .byte_to_sfr   (byte_to_sfr),
        .reg_req       (reg_req),
        .reg_we        (reg_we),
        .reg_wdata     (reg_wdata),
        .reg_ram_addr  (reg_ram_addr),
        .bit_req       (bit_req),
        .bit_we        (bit_we),
        .bit_wdata     (bit_wdata),
        .bit_addr      (bit_addr),
        .bit_ram_addr  (bit_ram_addr),
        .bit_pos       (bit_pos),
        .bit_to_sfr    (bit_to_sfr),
        .bit_byte      (bit_byte),
        .grant         (grant),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .mem_wdata     (mem_wdata),
        .sfr_req       (sfr_req),
        .sfr_addr      (sfr_addr),
        .sfr_we        (sfr_we),
        .sfr_wdata     (sfr_wdata),
        .sfr_bit       (sfr_bit)
    );

    // Return read data from RAM or from the SFR bus when forwarded.
    always_comb begin
        byte_rdata = byte_to_sfr ? sfr_rdata : rd_data[RD_BYTE];
        reg_rdata  = rd_data[RD_REG];
        bit_rdata  = bit_to_sfr ? sfr_rdata[0] : bit_byte[bit_pos];
    end
endmodule

// File: rtl/iram_bank_ctrl_chk.sv
// Module iram_bank_ctrl_chk
// Property checker for iram_bank_ctrl, attached through bind.
// Observes ports and the arbiter-to-store write signals.
module iram_bank_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bank_sel,
    input logic       byte_req,
    input logic       byte_indirect,
    input logic       reg_req,
    input logic [2:0] reg_num,
    input logic       bit_req,
    input logic [2:0] grant,
    input logic       mem_we,
    input logic [7:0] mem_waddr,
    input logic [7:0] mem_wdata,
    input logic [7:0] bit_byte,
    input logic       sfr_req,
    input logic       sfr_bit,
    input logic [7:0] sfr_addr
);
    // R10: nothing is written or forwarded during reset.
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> (!mem_we && !sfr_req));

    // R2: a forwarded access never also writes RAM.
    p_sfr_no_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_req |-> !mem_we);

    // R3: pointer accesses stay inside the RAM.
    p_indirect_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && byte_indirect) |-> !sfr_req);

    // R4 / R9: register writes land in the bank selected this cycle.
    p_reg_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[1] && mem_we) |-> (mem_waddr == {3'b000, bank_sel, reg_num}));

    // R5: bit writes stay in the bit field and flip at most one bit.
    p_bit_rmw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[2] && mem_we) |-> ($onehot0(mem_wdata ^ bit_byte) && mem_waddr[7:4] == 4'h2));

    // R6: a forwarded bit access names an upper bit address.
    p_bit_sfr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_req && sfr_bit) |-> (sfr_addr[7] && grant[2]));

    // R8: one winner, and the byte port always wins.
    p_grant_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_byte_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> (grant == 3'b001));
    p_reg_over_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_req && reg_req && bit_req) |-> (grant == 3'b010));
endmodule

bind iram_bank_ctrl iram_bank_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bank_sel      (bank_sel),
    .byte_req      (byte_req),
    .byte_indirect (byte_indirect),
    .reg_req       (reg_req),
    .reg_num       (reg_num),
    .bit_req       (bit_req),
    .grant         (grant),
    .mem_we        (mem_we),
    .mem_waddr     (mem_waddr),
    .mem_wdata     (mem_wdata),
    .bit_byte      (bit_byte),
    .sfr_req       (sfr_req),
    .sfr_bit       (sfr_bit),
    .sfr_addr      (sfr_addr)
);

// File: tb/iram_bank_ctrl_bench.sv
module iram_bank_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bank_sel;
    logic       byte_req, byte_indirect, byte_ptr_sel, byte_we;
    logic [7:0] byte_addr, byte_wdata, byte_rdata;
    logic       reg_req, reg_we;
    logic [2:0] reg_num;
    logic [7:0] reg_wdata, reg_rdata;
    logic       bit_req, bit_we, bit_wdata, bit_rdata;
    logic [7:0] bit_addr;
    logic       sfr_req, sfr_we, sfr_bit;
    logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model [256];

    always #2 clk = ~clk;

    iram_bank_ctrl u_iram_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .byte_req(byte_req), .byte_indirect(byte_indirect), .byte_ptr_sel(byte_ptr_sel),
        .byte_addr(byte_addr), .byte_we(byte_we), .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
        .reg_req(reg_req), .reg_num(reg_num), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_req(bit_req), .bit_addr(bit_addr), .bit_we(bit_we), .bit_wdata(bit_wdata), .bit_rdata(bit_rdata),
        .sfr_req(sfr_req), .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
        .sfr_bit(sfr_bit), .sfr_rdata(sfr_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Wait for the rising edge, step past it and drop every request.
    task automatic edge_clear();
        @(posedge clk); #1;
        byte_req = 1'b0; reg_req = 1'b0; bit_req = 1'b0;
        byte_we = 1'b0; reg_we = 1'b0; bit_we = 1'b0;
    endtask

    task automatic byte_op(input logic ind, input logic sel, input logic [7:0] a,
                           input logic we, input logic [7:0] d);
        @(negedge clk);
        byte_req = 1'b1; byte_indirect = ind; byte_ptr_sel = sel;
        byte_addr = a; byte_we = we; byte_wdata = d;
        #1;
    endtask

    task automatic reg_op(input logic [2:0] n, input logic we, input logic [7:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_num = n; reg_we = we; reg_wdata = d;
        #1;
    endtask

    task automatic bit_op(input logic [7:0] a, input logic we, input logic v);
        @(negedge clk);
        bit_req = 1'b1; bit_addr = a; bit_we = we; bit_wdata = v;
        #1;
    endtask

    // Direct read of a low-half byte, compared against the shadow model.
    task automatic read_low(input string tag, input logic [7:0] a);
        byte_op(1'b0, 1'b0, a, 1'b0, 8'h00);
        check(tag, byte_rdata, model[a]);
        edge_clear();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bank_sel = 2'd0;
        byte_req = 0; byte_indirect = 0; byte_ptr_sel = 0; byte_addr = 0; byte_we = 0; byte_wdata = 0;
        reg_req = 0; reg_num = 0; reg_we = 0; reg_wdata = 0;
        bit_req = 0; bit_addr = 0; bit_we = 0; bit_wdata = 0;
        sfr_rdata = 8'h00;
        repeat (2) @(posedge clk);

        // R10: during reset a direct upper access is not forwarded.
        byte_op(1'b0, 1'b0, 8'h90, 1'b1, 8'h55);
        check("R10 sfr_req in reset", {7'b0, sfr_req}, 8'h00);
        edge_clear();
        @(negedge clk); rst_n = 1'b1;

        // R10: a write attempted during reset is dropped, contents retained.
        byte_op(1'b0, 1'b0, 8'h10, 1'b1, 8'h11); edge_clear(); model[8'h10] = 8'h11;
        @(negedge clk); rst_n = 1'b0;
        byte_op(1'b0, 1'b0, 8'h10, 1'b1, 8'h22); edge_clear();
        @(negedge clk); rst_n = 1'b1;
        read_low("R10 retained", 8'h10);

        // R1: sweep every low byte with direct writes, then read back.
        for (int a = 0; a < 128; a++) begin
            byte_op(1'b0, 1'b0, 8'(a), 1'b1, 8'(a) ^ 8'h5A);
            check("R1 no forward", {7'b0, sfr_req}, 8'h00);
            edge_clear();
            model[a] = 8'(a) ^ 8'h5A;
        end
        for (int a = 0; a < 128; a++) read_low("R1 readback", 8'(a));

        // R7: old value before the edge, new value after; we=0 writes nothing.
        byte_op(1'b0, 1'b0, 8'h50, 1'b1, 8'h34);
        check("R7 before edge", byte_rdata, model[8'h50]);
        @(posedge clk); #1;
        check("R7 after edge", byte_rdata, 8'h34);
        edge_clear(); model[8'h50] = 8'h34;
        byte_op(1'b0, 1'b0, 8'h50, 1'b0, 8'hEE); edge_clear();
        read_low("R7 we low", 8'h50);

        // R4: every register of every bank, checked through direct bytes.
        for (int b = 0; b < 4; b++) begin
            for (int n = 0; n < 8; n++) begin
                @(negedge clk); bank_sel = 2'(b);
                reg_op(3'(n), 1'b1, {3'b101, 2'(b), 3'(n)});
                edge_clear();
                model[{3'b000, 2'(b), 3'(n)}] = {3'b101, 2'(b), 3'(n)};
            end
        end
        for (int a = 0; a < 32; a++) read_low("R4 bank map", 8'(a));
        @(negedge clk); bank_sel = 2'd2;
        reg_op(3'd5, 1'b0, 8'h00);
        check("R4 reg_rdata", reg_rdata, model[8'h15]);
        edge_clear();

        // R3: fill the upper half through R0 of bank 0.
        for (int a = 128; a < 256; a++) begin
            @(negedge clk); bank_sel = 2'd0;
            reg_op(3'd0, 1'b1, 8'(a)); edge_clear(); model[0] = 8'(a);
            byte_op(1'b1, 1'b0, 8'h00, 1'b1, ~8'(a));
            check("R3 indirect no forward", {7'b0, sfr_req}, 8'h00);
            edge_clear(); model[a] = ~8'(a);
        end

        // R2: direct upper accesses are forwarded and leave RAM alone.
        for (int a = 128; a < 256; a++) begin
            @(negedge clk); sfr_rdata = 8'(a) ^ 8'hF0;
            byte_op(1'b0, 1'b0, 8'(a), 1'b1, 8'(a) + 8'd1);
            check("R2 sfr_req", {7'b0, sfr_req}, 8'h01);
            check("R2 sfr_addr", sfr_addr, 8'(a));
            check("R2 sfr_we/bit", {6'b0, sfr_we, sfr_bit}, 8'h02);
            check("R2 sfr_wdata", sfr_wdata, 8'(a) + 8'd1);
            check("R2 rdata", byte_rdata, 8'(a) ^ 8'hF0);
            edge_clear();
        end
        // R3: read the upper half back through R1 of bank 3.
        for (int a = 128; a < 256; a++) begin
            @(negedge clk); bank_sel = 2'd3;
            reg_op(3'd1, 1'b1, 8'(a)); edge_clear(); model[8'h19] = 8'(a);
            byte_op(1'b1, 1'b1, 8'h00, 1'b0, 8'h00);
            check("R3/R2 upper intact", byte_rdata, model[a]);
            edge_clear();
        end

        // R9: bank switch and indirect read in the same cycle.
        @(negedge clk); bank_sel = 2'd1;
        reg_op(3'd0, 1'b1, 8'h44); edge_clear(); model[8'h08] = 8'h44;
        @(negedge clk); bank_sel = 2'd3;
        reg_op(3'd0, 1'b1, 8'h33); edge_clear(); model[8'h18] = 8'h33;
        @(negedge clk); bank_sel = 2'd1;
        @(negedge clk);
        bank_sel = 2'd3; byte_req = 1'b1; byte_indirect = 1'b1; byte_ptr_sel = 1'b0; byte_we = 1'b0;
        #1;
        check("R9 same-cycle bank", byte_rdata, model[8'h33]);
        edge_clear();

        // R5: set mixed patterns, then write every low bit address.
        for (int i = 0; i < 16; i++) begin
            byte_op(1'b0, 1'b0, 8'h20 + 8'(i), 1'b1, 8'hA5 ^ 8'(i * 17));
            edge_clear(); model[8'h20 + i] = 8'hA5 ^ 8'(i * 17);
        end
        for (int b = 0; b < 128; b++) begin
            logic v;
            v = b[0] ^ b[3] ^ b[5];
            bit_op(8'(b), 1'b1, v);
            check("R5 bit read", {7'b0, bit_rdata}, {7'b0, model[8'h20 + (b >> 3)][b % 8]});
            edge_clear();
            model[8'h20 + (b >> 3)][b % 8] = v;
            read_low("R5 byte after bit write", 8'h20 + 8'(b >> 3));
        end

        // R6: upper bit addresses are forwarded with the bit flag.
        for (int b = 128; b < 256; b++) begin
            @(negedge clk); sfr_rdata = {7'b0, ~b[0]};
            bit_op(8'(b), 1'b1, b[1]);
            check("R6 sfr_req/bit", {6'b0, sfr_req, sfr_bit}, 8'h03);
            check("R6 sfr_addr", sfr_addr, 8'(b));
            check("R6 sfr_wdata", sfr_wdata, {7'b0, b[1]});
            check("R6 bit_rdata", {7'b0, bit_rdata}, {7'b0, ~b[0]});
            edge_clear();
        end
        for (int i = 0; i < 16; i++) read_low("R6 bit field intact", 8'h20 + 8'(i));

        // R8: byte, register and bit writes in one cycle; only the byte lands.
        @(negedge clk);
        bank_sel = 2'd0;
        byte_req = 1; byte_indirect = 0; byte_addr = 8'h40; byte_we = 1; byte_wdata = 8'h99;
        reg_req = 1; reg_num = 3'd2; reg_we = 1; reg_wdata = 8'h77;
        bit_req = 1; bit_addr = 8'h00; bit_we = 1; bit_wdata = ~model[8'h20][0];
        #1;
        check("R8 loser reg_rdata", reg_rdata, model[8'h02]);
        edge_clear(); model[8'h40] = 8'h99;
        read_low("R8 byte won", 8'h40);
        read_low("R8 reg dropped", 8'h02);
        read_low("R8 bit dropped", 8'h20);
        // R8: register beats bit when the byte port is idle.
        @(negedge clk);
        reg_req = 1; reg_num = 3'd3; reg_we = 1; reg_wdata = 8'h6C;
        bit_req = 1; bit_addr = 8'h88; bit_we = 1; bit_wdata = 1'b1;
        #1;
        check("R8 bit not forwarded", {7'b0, sfr_req}, 8'h00);
        edge_clear(); model[8'h03] = 8'h6C;
        read_low("R8 reg won", 8'h03);
        // R8: direct upper byte beats upper bit on the SFR bus.
        @(negedge clk);
        byte_req = 1; byte_indirect = 0; byte_addr = 8'h85; byte_we = 0;
        bit_req = 1; bit_addr = 8'h90; bit_we = 0;
        #1;
        check("R8 sfr owner", sfr_addr, 8'h85);
        check("R8 sfr_bit", {7'b0, sfr_bit}, 8'h00);
        edge_clear();

        finish_run();
    end
endmodule